// File: doc/BRIEF.md
# Timer Register Access Port

This block is the bus-facing register front end of a timer unit whose registers are all 64 bits wide. A bus master issues single-cycle requests carrying a byte count of 4 or 8, a byte offset and write data. The block checks size and alignment, decodes the offset, and maps a 4-byte access onto the low or high half of a 64-bit register. Each write becomes a 64-bit masked merge, so a half-width write leaves the other half untouched.

The block holds the general configuration and, for each channel, the configuration, comparator and message registers. Each channel configuration keeps its read-only capability fields whatever is written. The main counter and the interrupt status live in neighbouring blocks. For those two the port supplies the merged value or the clear bits through a one-cycle strobe. Every accepted write raises exactly one decoded strobe, together with the new 64-bit register value. Every read returns its data one cycle after the request.

Top module: `tmr_regport`

## Requirements
- R1: `req_size` is a byte count; only 4 and 8 are accepted. A write of any other size changes no register and raises no strobe. A read of any other size returns 0.
- R2: An access whose offset is not a multiple of its size is dropped: no strobe, no register change, and a read returns 0.
- R3: A 4-byte access with offset bit 2 set reaches bits 63:32 of the register, and one with bit 2 clear reaches bits 31:0. A 4-byte read returns that half in `rd_data_o[31:0]` with bits 63:32 zero.
- R4: A write produces (old AND NOT mask) OR (data AND mask). The mask is all ones for 8 bytes and one 32-bit half for 4 bytes. The data for a 4-byte write is `req_wdata[31:0]` placed in the addressed half.
- R5: On a channel configuration write, bits 63:32 (allowed routes), bit 15 (message capable) and bit 4 (periodic capable) keep their previous value.
- R6: After reset, every channel configuration reads 0x8010, every comparator reads 0x00000000FFFFFFFF, and the general configuration and message registers read 0.
- R7: A counter write merges into the zero-extended 32-bit `cnt_i` and raises `wr_cnt_o` with the result. A counter read returns `cnt_i` zero-extended.
- R8: Offsets are decoded as follows, and each write raises only the matching strobe:
  - 0x000: capability
  - 0x010: general configuration
  - 0x020: status
  - 0x0F0: counter
  - channel n (stride 0x20): configuration at 0x100+0x20n, comparator at 0x108+0x20n, message at 0x110+0x20n
- R9: A status read returns `stat_i` in the low NCH bits with zeros above. A status write raises `wr_stat_o` with (data AND mask) limited to the low NCH bits, as clear bits.
- R10: Reads of unmapped offsets return 0. Writes to them raise no strobe and change no register.
- R11: The capability register reads the parameter CAP_VALUE. Writes to it raise no strobe.
- R12: Read data and write strobes appear on the clock edge after the request. At most one strobe is high at a time, and none with `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Byte offset |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data (low 32 bits for 4-byte writes) |
| cnt_i | input | 32 | Current main counter value |
| stat_i | input | NCH | Current interrupt status bits |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 64 | Read response data |
| wr_gcfg_o | output | 1 | General configuration written |
| wr_stat_o | output | 1 | Status clear request |
| wr_cnt_o | output | 1 | Counter load request |
| wr_ch_cfg_o | output | NCH | Channel configuration written, one bit per channel |
| wr_ch_cmp_o | output | NCH | Channel comparator written |
| wr_ch_msg_o | output | NCH | Channel message register written |
| wr_data_o | output | 64 | New value for the strobed register |
| gcfg_o | output | 64 | General configuration contents |
| ch_cfg_o | output | 64*NCH | Channel configurations, channel n at bits 64n+63:64n |
| ch_cmp_o | output | 64*NCH | Channel comparators |
| ch_msg_o | output | 64*NCH | Channel message registers |

## Verification
Every channel register is swept with a full-width write followed by an upper-half and a lower-half write. Each pattern carries distinct bytes per channel and register, so a wrong half, a lost merge, a misrouted strobe or a broken read-only field shows up as a specific mismatch. All sixteen size codes are then tried against one register, to separate accepted sizes from dropped ones. Misaligned offsets, unmapped holes inside and outside the channel window, and the capability register are checked to leave the registers untouched. The counter and status paths are driven with fixed input values, so zero-extension and the clear-bit masking can be told apart from a plain pass-through.

// File: rtl/tmr_regport_pkg.sv
package tmr_regport_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_GCFG,
    SEL_STAT,
    SEL_CNT,
    SEL_CCFG,
    SEL_CCMP,
    SEL_CMSG
  } sel_e;

  // channel config fields that writes never change
  localparam logic [63:0] CH_CFG_RO  = 64'hFFFF_FFFF_0000_8010;
  localparam logic [63:0] CH_CFG_RST = 64'h0000_0000_0000_8010;
  localparam logic [63:0] CH_CMP_RST = 64'h0000_0000_FFFF_FFFF;

  function automatic logic [63:0] mask_merge(input logic [63:0] old_v,
                                             input logic [63:0] dat,
                                             input logic [63:0] msk);
    return (old_v & ~msk) | (dat & msk);
  endfunction

endpackage

// File: rtl/tmr_regport_dec.sv
module tmr_regport_dec
  import tmr_regport_pkg::*;
#(
  parameter int AW  = 12,
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic [AW-1:0]  addr,
  input  logic [3:0]     size,
  output logic           ok,
  output logic           hi,
  output sel_e           sel,
  output logic [CHW-1:0] ch
);

  localparam int WAW = AW - 3;
  localparam logic [WAW-1:0] W_CAP  = WAW'(0);
  localparam logic [WAW-1:0] W_GCFG = WAW'(2);
  localparam logic [WAW-1:0] W_STAT = WAW'(4);
  localparam logic [WAW-1:0] W_CNT  = WAW'(30);
  localparam logic [WAW-1:0] W_CH0  = WAW'(32);
  localparam int CH_WORDS = 4 * NCH;

  logic [WAW-1:0] wa;
  logic [WAW-1:0] rel;
  logic           size_ok;
  logic           align_ok;
  logic           in_ch;

  always_comb begin
    wa       = addr[AW-1:3];
    size_ok  = (size == 4'd4) || (size == 4'd8);
    align_ok = (size == 4'd8) ? (addr[2:0] == 3'd0) : (addr[1:0] == 2'd0);
    ok       = size_ok && align_ok;
    hi       = (size == 4'd4) && addr[2];
    rel      = wa - W_CH0;
    in_ch    = (wa >= W_CH0) && (int'(rel) < CH_WORDS);
    ch       = CHW'(rel >> 2);
    sel      = SEL_NONE;
    if (wa == W_CAP)       sel = SEL_CAP;
    else if (wa == W_GCFG) sel = SEL_GCFG;
    else if (wa == W_STAT) sel = SEL_STAT;
    else if (wa == W_CNT)  sel = SEL_CNT;
    else if (in_ch) begin
      case (rel[1:0])
        2'd0:    sel = SEL_CCFG;
        2'd1:    sel = SEL_CCMP;
        2'd2:    sel = SEL_CMSG;
        default: sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/tmr_regport_chan.sv
module tmr_regport_chan
  import tmr_regport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_cfg,
  input  logic        ld_cmp,
  input  logic        ld_msg,
  input  logic [63:0] nv,
  output logic [63:0] cfg_q,
  output logic [63:0] cmp_q,
  output logic [63:0] msg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CH_CFG_RST;
      cmp_q <= CH_CMP_RST;
      msg_q <= '0;
    end else begin
      if (ld_cfg) cfg_q <= nv;
      if (ld_cmp) cmp_q <= nv;
      if (ld_msg) msg_q <= nv;
    end
  end

endmodule

// File: rtl/tmr_regport.sv
module tmr_regport
  import tmr_regport_pkg::*;
#(
  parameter int          NCH       = 8,
  parameter int          AW        = 12,
  parameter logic [63:0] CAP_VALUE = 64'h05F5_E100_0000_0701
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [31:0]       cnt_i,
  input  logic [NCH-1:0]    stat_i,
  output logic              rd_valid_o,
  output logic [63:0]       rd_data_o,
  output logic              wr_gcfg_o,
  output logic              wr_stat_o,
  output logic              wr_cnt_o,
  output logic [NCH-1:0]    wr_ch_cfg_o,
  output logic [NCH-1:0]    wr_ch_cmp_o,
  output logic [NCH-1:0]    wr_ch_msg_o,
  output logic [63:0]       wr_data_o,
  output logic [63:0]       gcfg_o,
  output logic [NCH*64-1:0] ch_cfg_o,
  output logic [NCH*64-1:0] ch_cmp_o,
  output logic [NCH*64-1:0] ch_msg_o
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [63:0] STAT_MASK = (64'd1 << NCH) - 64'd1;
  localparam logic [63:0] LO_MASK   = 64'h0000_0000_FFFF_FFFF;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_int_n = rsync[1];

  // decode
  logic           acc_ok;
  logic           acc_hi;
  sel_e           acc_sel;
  logic [CHW-1:0] acc_ch;

  tmr_regport_dec #(.AW(AW), .NCH(NCH), .CHW(CHW)) u_dec (
    .addr(req_addr),
    .size(req_size),
    .ok  (acc_ok),
    .hi  (acc_hi),
    .sel (acc_sel),
    .ch  (acc_ch)
  );

  // channel storage
  logic [63:0]    cfg_a [NCH];
  logic [63:0]    cmp_a [NCH];
  logic [63:0]    msg_a [NCH];
  logic [NCH-1:0] ld_cfg_n, ld_cmp_n, ld_msg_n;
  logic [63:0]    nv;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_regport_chan u_ch (
      .clk   (clk),
      .rst_n (rst_int_n),
      .ld_cfg(ld_cfg_n[i]),
      .ld_cmp(ld_cmp_n[i]),
      .ld_msg(ld_msg_n[i]),
      .nv    (nv),
      .cfg_q (cfg_a[i]),
      .cmp_q (cmp_a[i]),
      .msg_q (msg_a[i])
    );
    assign ch_cfg_o[i*64 +: 64] = cfg_a[i];
    assign ch_cmp_o[i*64 +: 64] = cmp_a[i];
    assign ch_msg_o[i*64 +: 64] = msg_a[i];
  end

  // next-state logic
  logic        wr_acc, rd_req, wr_en;
  logic [63:0] wd, wm, old_v, merged, full_v, rv;
  logic        ld_gcfg_n, ld_stat_n, ld_cnt_n;
  logic [63:0] gcfg_q;

  always_comb begin
    wr_acc = req_valid && req_write && acc_ok;
    rd_req = req_valid && !req_write;

    if (req_size == 4'd8) begin
      wm = '1;
      wd = req_wdata;
    end else if (acc_hi) begin
      wm = ~LO_MASK;
      wd = {req_wdata[31:0], 32'h0};
    end else begin
      wm = LO_MASK;
      wd = {32'h0, req_wdata[31:0]};
    end

    case (acc_sel)
      SEL_CAP:  full_v = CAP_VALUE;
      SEL_GCFG: full_v = gcfg_q;
      SEL_STAT: full_v = 64'(stat_i);
      SEL_CNT:  full_v = {32'h0, cnt_i};
      SEL_CCFG: full_v = cfg_a[acc_ch];
      SEL_CCMP: full_v = cmp_a[acc_ch];
      SEL_CMSG: full_v = msg_a[acc_ch];
      default:  full_v = '0;
    endcase

    old_v  = (acc_sel == SEL_STAT || acc_sel == SEL_CAP) ? '0 : full_v;
    merged = mask_merge(old_v, wd, wm);
    if (acc_sel == SEL_CCFG)      nv = (merged & ~CH_CFG_RO) | (old_v & CH_CFG_RO);
    else if (acc_sel == SEL_STAT) nv = wd & wm & STAT_MASK;
    else                          nv = merged;

    if (!acc_ok)                rv = '0;
    else if (req_size == 4'd8)  rv = full_v;
    else if (acc_hi)            rv = {32'h0, full_v[63:32]};
    else                        rv = {32'h0, full_v[31:0]};

    ld_gcfg_n = wr_acc && (acc_sel == SEL_GCFG);
    ld_stat_n = wr_acc && (acc_sel == SEL_STAT);
    ld_cnt_n  = wr_acc && (acc_sel == SEL_CNT);
    ld_cfg_n  = (wr_acc && acc_sel == SEL_CCFG) ? (NCH'(1) << acc_ch) : '0;
    ld_cmp_n  = (wr_acc && acc_sel == SEL_CCMP) ? (NCH'(1) << acc_ch) : '0;
    ld_msg_n  = (wr_acc && acc_sel == SEL_CMSG) ? (NCH'(1) << acc_ch) : '0;
    wr_en     = ld_gcfg_n || ld_stat_n || ld_cnt_n ||
                (|ld_cfg_n) || (|ld_cmp_n) || (|ld_msg_n);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
      wr_gcfg_o   <= 1'b0;
      wr_stat_o   <= 1'b0;
      wr_cnt_o    <= 1'b0;
      wr_ch_cfg_o <= '0;
      wr_ch_cmp_o <= '0;
      wr_ch_msg_o <= '0;
      wr_data_o   <= '0;
      gcfg_q      <= '0;
    end else begin
      rd_valid_o  <= rd_req;
      wr_gcfg_o   <= ld_gcfg_n;
      wr_stat_o   <= ld_stat_n;
      wr_cnt_o    <= ld_cnt_n;
      wr_ch_cfg_o <= ld_cfg_n;
      wr_ch_cmp_o <= ld_cmp_n;
      wr_ch_msg_o <= ld_msg_n;
      if (rd_req)    rd_data_o <= rv;
      if (wr_en)     wr_data_o <= nv;
      if (ld_gcfg_n) gcfg_q    <= nv;
    end
  end

  assign gcfg_o = gcfg_q;

endmodule

// File: rtl/tmr_regport_chk.sv
module tmr_regport_chk
  import tmr_regport_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic [3:0]        req_size,
  input logic              rd_valid_o,
  input logic [63:0]       rd_data_o,
  input logic              wr_gcfg_o,
  input logic              wr_stat_o,
  input logic              wr_cnt_o,
  input logic [NCH-1:0]    wr_ch_cfg_o,
  input logic [NCH-1:0]    wr_ch_cmp_o,
  input logic [NCH-1:0]    wr_ch_msg_o,
  input logic [63:0]       wr_data_o,
  input logic [NCH*64-1:0] ch_cfg_o
);

  logic [3*NCH+2:0] strb;
  logic             any_strb;
  logic             bad_size;
  assign strb     = {wr_gcfg_o, wr_stat_o, wr_cnt_o, wr_ch_cfg_o, wr_ch_cmp_o, wr_ch_msg_o};
  assign any_strb = |strb;
  assign bad_size = !(req_size == 4'd4 || req_size == 4'd8);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb)); // R12
  AST_RD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> !any_strb); // R12
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rd_valid_o); // R12
  AST_BAD_SIZE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && bad_size |=> !any_strb); // R1
  AST_BAD_SIZE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && bad_size |=> rd_data_o == 64'h0); // R1
  AST_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_size == 4'd8 && req_addr[2:0] != 3'd0 |=> !any_strb); // R2
  AST_HALF_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_size == 4'd4 |=> rd_data_o[63:32] == 32'h0); // R3
  AST_STAT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat_o |-> wr_data_o[63:NCH] == '0); // R9
  AST_CAP_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr[AW-1:3] == '0 |=> !any_strb); // R11
  AST_CNT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_size == 4'd4 && req_addr == AW'(12'h0F0)
    |=> wr_cnt_o && wr_data_o[63:32] == 32'h0); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_ro
    AST_CFG_RO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ch_cfg_o[i*64 +: 64] & CH_CFG_RO)); // R5
  end

endmodule

bind tmr_regport tmr_regport_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .wr_gcfg_o  (wr_gcfg_o),
  .wr_stat_o  (wr_stat_o),
  .wr_cnt_o   (wr_cnt_o),
  .wr_ch_cfg_o(wr_ch_cfg_o),
  .wr_ch_cmp_o(wr_ch_cmp_o),
  .wr_ch_msg_o(wr_ch_msg_o),
  .wr_data_o  (wr_data_o),
  .ch_cfg_o   (ch_cfg_o)
);

// File: tb/sim_tmr_regport.sv
`timescale 1ns/1ps
module sim_tmr_regport;

  localparam int NCH = 8;
  localparam int SW  = 3 * NCH + 3;
  localparam logic [63:0] CAP = 64'h05F5_E100_0000_0701;
  localparam logic [63:0] RO  = 64'hFFFF_FFFF_0000_8010;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_write;
  logic [11:0]       req_addr;
  logic [3:0]        req_size;
  logic [63:0]       req_wdata;
  logic [31:0]       cnt_i;
  logic [NCH-1:0]    stat_i;
  logic              rd_valid_o;
  logic [63:0]       rd_data_o;
  logic              wr_gcfg_o, wr_stat_o, wr_cnt_o;
  logic [NCH-1:0]    wr_ch_cfg_o, wr_ch_cmp_o, wr_ch_msg_o;
  logic [63:0]       wr_data_o, gcfg_o;
  logic [NCH*64-1:0] ch_cfg_o, ch_cmp_o, ch_msg_o;

  tmr_regport #(.NCH(NCH), .AW(12), .CAP_VALUE(CAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .cnt_i(cnt_i), .stat_i(stat_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .wr_gcfg_o(wr_gcfg_o), .wr_stat_o(wr_stat_o), .wr_cnt_o(wr_cnt_o),
    .wr_ch_cfg_o(wr_ch_cfg_o), .wr_ch_cmp_o(wr_ch_cmp_o), .wr_ch_msg_o(wr_ch_msg_o),
    .wr_data_o(wr_data_o), .gcfg_o(gcfg_o), .ch_cfg_o(ch_cfg_o),
    .ch_cmp_o(ch_cmp_o), .ch_msg_o(ch_msg_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic          o_rdv;
  logic [63:0]   o_rd, o_wd;
  logic [SW-1:0] o_st;

  logic [63:0] m_gcfg;
  logic [63:0] m_reg [NCH][3];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [11:0] a, input logic [3:0] s,
                      input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    o_rdv = rd_valid_o;
    o_rd  = rd_data_o;
    o_wd  = wr_data_o;
    o_st  = {wr_gcfg_o, wr_stat_o, wr_cnt_o, wr_ch_cfg_o, wr_ch_cmp_o, wr_ch_msg_o};
  endtask

  function automatic logic [SW-1:0] ch_bit(input int ch, input int sub);
    return SW'(1) << (ch + (2 - sub) * NCH);
  endfunction

  // readback of every channel register against the model
  task automatic sweep_readback(input string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      for (int sub = 0; sub < 3; sub++) begin
        xfer(1'b0, 12'(32'h100 + ch * 32 + sub * 8), 4'd8, 64'h0);
        check(tag, o_rd, m_reg[ch][sub]);
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; cnt_i = '0; stat_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: idle outputs after reset
    check("R12 idle rd_valid", 64'(rd_valid_o), 64'h0);
    check("R12 idle strobes", 64'({wr_gcfg_o, wr_stat_o, wr_cnt_o, wr_ch_cfg_o,
                                     wr_ch_cmp_o, wr_ch_msg_o}), 64'h0);

    // R6: reset values
    m_gcfg = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      m_reg[ch][0] = 64'h8010;
      m_reg[ch][1] = 64'h0000_0000_FFFF_FFFF;
      m_reg[ch][2] = 64'h0;
    end
    sweep_readback("R6 reset value");
    xfer(1'b0, 12'h010, 4'd8, 64'h0);
    check("R6 gcfg reset", o_rd, 64'h0);
    check("R12 read valid", 64'(o_rdv), 64'h1);

    // R4 R5 R8 R3: full and half writes on every channel register
    for (int ch = 0; ch < NCH; ch++) begin
      for (int sub = 0; sub < 3; sub++) begin
        logic [11:0] base;
        logic [63:0] p, e;
        logic [31:0] q;
        base = 12'(32'h100 + ch * 32 + sub * 8);
        p = 64'hA5C3_0F96_5A3C_F069 + 64'(ch) * 64'h0101_0101_0101_0101
            + 64'(sub) * 64'h1000_0001_1000_0001;
        e = (sub == 0) ? ((p & ~RO) | (m_reg[ch][0] & RO)) : p;
        xfer(1'b1, base, 4'd8, p);
        check("R8 strobe", 64'(o_st), 64'(ch_bit(ch, sub)));
        check(sub == 0 ? "R5 full write" : "R4 full write", o_wd, e);
        m_reg[ch][sub] = e;

        q = p[31:0] ^ 32'hFFFF_0000;
        e = (sub == 0) ? m_reg[ch][0] : {q, m_reg[ch][sub][31:0]};
        xfer(1'b1, base + 12'h4, 4'd4, {32'hDEAD_BEEF, q});
        check(sub == 0 ? "R5 upper write" : "R4 upper write", o_wd, e);
        m_reg[ch][sub] = e;

        q = ~p[63:32];
        e = {m_reg[ch][sub][63:32], q};
        if (sub == 0) e = (e & ~RO) | (m_reg[ch][0] & RO);
        xfer(1'b1, base, 4'd4, {32'h1357_9BDF, q});
        check("R4 lower write", o_wd, e);
        m_reg[ch][sub] = e;

        xfer(1'b0, base, 4'd8, 64'h0);
        check("R8 full read", o_rd, m_reg[ch][sub]);
        xfer(1'b0, base + 12'h4, 4'd4, 64'h0);
        check("R3 upper read", o_rd, {32'h0, m_reg[ch][sub][63:32]});
        xfer(1'b0, base, 4'd4, 64'h0);
        check("R3 lower read", o_rd, {32'h0, m_reg[ch][sub][31:0]});
      end
    end

    // general config
    xfer(1'b1, 12'h010, 4'd8, 64'h0123_4567_89AB_CDEF);
    check("R8 gcfg strobe", 64'(o_st), 64'(SW'(1) << (SW - 1)));
    m_gcfg = 64'h0123_4567_89AB_CDEF;
    xfer(1'b1, 12'h014, 4'd4, 64'h0000_0000_7777_8888);
    m_gcfg = {32'h7777_8888, m_gcfg[31:0]};
    check("R4 gcfg half", gcfg_o, m_gcfg);

    // R1: all size codes
    for (int s = 0; s < 16; s++) begin
      if (s != 4 && s != 8) begin
        xfer(1'b1, 12'h010, 4'(s), 64'hFFFF_FFFF_FFFF_FFFF);
        check("R1 bad size write", 64'(o_st), 64'h0);
        xfer(1'b0, 12'h010, 4'(s), 64'h0);
        check("R1 bad size read", o_rd, 64'h0);
      end
    end
    xfer(1'b0, 12'h010, 4'd8, 64'h0);
    check("R1 gcfg untouched", o_rd, m_gcfg);

    // R2: misaligned
    xfer(1'b1, 12'h014, 4'd8, 64'h0);
    check("R2 misaligned 8 write", 64'(o_st), 64'h0);
    xfer(1'b1, 12'h012, 4'd4, 64'h0);
    check("R2 misaligned 4 write", 64'(o_st), 64'h0);
    xfer(1'b0, 12'h011, 4'd4, 64'h0);
    check("R2 misaligned read", o_rd, 64'h0);
    xfer(1'b0, 12'h010, 4'd8, 64'h0);
    check("R2 gcfg untouched", o_rd, m_gcfg);

    // R7: counter
    cnt_i = 32'h1234_5678;
    xfer(1'b0, 12'h0F0, 4'd8, 64'h0);
    check("R7 counter read", o_rd, 64'h0000_0000_1234_5678);
    xfer(1'b0, 12'h0F4, 4'd4, 64'h0);
    check("R7 counter upper read", o_rd, 64'h0);
    xfer(1'b1, 12'h0F4, 4'd4, 64'h1111_1111_CAFE_F00D);
    check("R7 counter strobe", 64'(o_st), 64'(SW'(1) << (SW - 3)));
    check("R7 counter upper write", o_wd, 64'hCAFE_F00D_1234_5678);
    xfer(1'b1, 12'h0F0, 4'd4, 64'hFFFF_FFFF_0000_0009);
    check("R7 counter lower write", o_wd, 64'h0000_0000_0000_0009);

    // R9: status
    stat_i = 8'hA5;
    xfer(1'b0, 12'h020, 4'd8, 64'h0);
    check("R9 status read", o_rd, 64'hA5);
    xfer(1'b1, 12'h020, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R9 status strobe", 64'(o_st), 64'(SW'(1) << (SW - 2)));
    check("R9 status clear bits", o_wd, 64'hFF);
    xfer(1'b1, 12'h024, 4'd4, 64'h0000_0000_FFFF_FFFF);
    check("R9 status upper write", o_wd, 64'h0);
    xfer(1'b1, 12'h020, 4'd4, 64'h0000_0000_0000_003C);
    check("R9 status lower write", o_wd, 64'h3C);

    // R10: unmapped offsets
    begin
      logic [11:0] holes [8];
      holes = '{12'h008, 12'h018, 12'h030, 12'h0E8, 12'h118, 12'h1F8, 12'h200, 12'h3F0};
      for (int k = 0; k < 8; k++) begin
        xfer(1'b1, holes[k], 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 hole write", 64'(o_st), 64'h0);
        xfer(1'b0, holes[k], 4'd8, 64'h0);
        check("R10 hole read", o_rd, 64'h0);
      end
    end
    sweep_readback("R10 registers untouched");

    // R11: capability
    xfer(1'b0, 12'h000, 4'd8, 64'h0);
    check("R11 cap read", o_rd, CAP);
    xfer(1'b0, 12'h004, 4'd4, 64'h0);
    check("R11 cap upper read", o_rd, {32'h0, CAP[63:32]});
    xfer(1'b1, 12'h000, 4'd8, 64'h0);
    check("R11 cap write strobe", 64'(o_st), 64'h0);
    xfer(1'b0, 12'h000, 4'd8, 64'h0);
    check("R11 cap unchanged", o_rd, CAP);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule